// File: doc/BRIEF.md
# Two-Word Command Port Decoder

This block interprets 16-bit writes that arrive at the command port of a video controller. A command word does one of two things. It loads one byte-wide configuration register from a single word, or it begins an access-setup command that spans two words. A latch remembers that the second word of a setup is still owed. That latch decides how the next command word is read, so one bit pattern can mean different things depending on what came before it.

A setup command builds a 16-bit access address and a 6-bit access code. Each of the two words supplies a different slice of each value, and the slices the word does not supply keep their earlier contents.

A write strobe on the data port abandons any half-finished setup. A separate increment pulse advances the address by the value held in the auto-increment register, so the surrounding logic can step the address after each data transfer. The address, the code, the pending flag and the full register file are all visible at the outputs.

Top module: `cmd_port_decoder`

## Requirements
- R1: On a clock edge with `rst_n` low, the address, the access code, the pending flag and every register become zero.
- R2: A command word whose bits 15:14 equal binary 10, written while nothing is pending, loads its bits 7:0 into register number bits 12:8. This is a register write. It leaves the address, the code and the pending flag unchanged.
- R3: A register write whose index (bits 12:8) is 24 or more changes no register.
- R4: Any other command word written while nothing is pending is a first setup word. It replaces address bits 13:0 with its bits 13:0, keeps address bits 15:14, loads code bits 1:0 from its bits 15:14, keeps code bits 5:2, and sets the pending flag.
- R5: Any command word written while the pending flag is set is a second setup word, whatever its bits 15:14 hold. It replaces address bits 15:14 with its bits 1:0, keeps address bits 13:0, loads code bits 5:2 from its bits 7:4, keeps code bits 1:0, changes no register, and clears the pending flag.
- R6: A `data_wr` pulse clears the pending flag. If it arrives in the same cycle as a first setup word, the address and code still load, and the pending flag ends clear.
- R7: An `addr_inc` pulse in a cycle without a command write adds register 15 (the auto-increment register, zero-extended) to the address, modulo 2^16. Without either input, the address and code hold.
- R8: An `addr_inc` pulse in the same cycle as any command write is dropped. Only the command word's own effect on the address applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Command port write strobe, one cycle per word |
| cmd_data | input | 16 | Command word |
| data_wr | input | 1 | Data port write strobe; clears the pending flag |
| addr_inc | input | 1 | Advance the address by the auto-increment register |
| addr_o | output | 16 | Current access address |
| code_o | output | 6 | Current access code |
| pending_o | output | 1 | Second setup word is awaited |
| regs_o | output | 192 | Register file, register k at bits 8k+7:8k |

## Verification
The checker treats each strobe as a single-cycle event that is sampled on the rising edge. It makes no assumption about whether strobes collide, because the priority rules of R6 and R8 are written into the properties themselves. The bench drives every strobe for exactly one cycle between falling edges. It deliberately puts `data_wr` and `addr_inc` in the same cycle as command words, so that the collision paths are exercised rather than avoided. Address wrap is covered by pairing a near-maximum address with an increment of 0xFF.

// File: rtl/cmdp_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, the command kind encoding and the decoded-word
// record passed from the classifier to the state holders.
package cmdp_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 16;
    localparam int CODE_W  = 6;
    localparam int REG_W   = 8;
    localparam int IDX_W   = 5;
    localparam int LO_W    = 14;              // address bits carried by a first word
    localparam int HI_W    = ADDR_W - LO_W;   // address bits carried by a second word
    localparam int CLO_W   = 2;               // code bits carried by a first word
    localparam int CHI_W   = CODE_W - CLO_W;  // code bits carried by a second word

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_REG    = 2'd1,
        OP_FIRST  = 2'd2,
        OP_SECOND = 2'd3
    } cmd_op_e;

    typedef struct packed {
        cmd_op_e           op;
        logic [IDX_W-1:0]  idx;
        logic              idx_ok;
        logic [REG_W-1:0]  val;
        logic [LO_W-1:0]   addr_lo;
        logic [HI_W-1:0]   addr_hi;
        logic [CLO_W-1:0]  code_lo;
        logic [CHI_W-1:0]  code_hi;
    } cmd_dec_t;
endpackage

// File: rtl/cmdp_classify.sv
`timescale 1ns/1ps
// Module: cmdp_classify
// Purely combinational. Reads one command word together with the current
// pending flag and says which kind of command it is. It also slices out every
// field that the state holders might need.
// Assumes: cmd_wr is high for exactly one cycle per word.
module cmdp_classify
    import cmdp_pkg::*;
#(
    parameter int NUM_REGS = 24
) (
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              pending,
    output cmd_dec_t          dec
);
    localparam logic [1:0] REG_TAG = 2'b10;

    // Pick the kind of command from the strobe, the pending flag and the top bits.
    always_comb begin
        if (!cmd_wr)
            dec.op = OP_IDLE;
        else if (pending)
            dec.op = OP_SECOND;
        else if (cmd_data[15:14] == REG_TAG)
            dec.op = OP_REG;
        else
            dec.op = OP_FIRST;
    end

    // Slice out the register-write fields and range-check the index.
    always_comb begin
        dec.idx    = cmd_data[12:8];
        dec.val    = cmd_data[REG_W-1:0];
        dec.idx_ok = (int'(cmd_data[12:8]) < NUM_REGS);
    end

    // Slice out the address and code fragments that the setup words carry.
    always_comb begin
        dec.addr_lo = cmd_data[LO_W-1:0];
        dec.code_lo = cmd_data[15:14];
        dec.addr_hi = cmd_data[HI_W-1:0];
        dec.code_hi = cmd_data[7:4];
    end
endmodule

// File: rtl/cmdp_access_state.sv
`timescale 1ns/1ps
// Module: cmdp_access_state
// Holds the pending flag, the access address and the access code. It merges
// the slices that each setup word supplies into the stored values.
// Priority: a command word overrides the increment pulse, and a data strobe
// overrides the setting of the pending flag.
// Assumes: dec.op is OP_IDLE in every cycle without a command write.
module cmdp_access_state
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_dec_t          dec,
    input  logic              data_wr,
    input  logic              addr_inc,
    input  logic [REG_W-1:0]  inc_step,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] code,
    output logic              pending
);
    logic [ADDR_W-1:0] step_ext;
    assign step_ext = {{(ADDR_W-REG_W){1'b0}}, inc_step};

    // Pending latch: a first word sets it, a second word or a data write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (data_wr)
            pending <= 1'b0;
        else if (dec.op == OP_FIRST)
            pending <= 1'b1;
        else if (dec.op == OP_SECOND)
            pending <= 1'b0;
    end

    // Address: merge in the setup slices, otherwise step by the auto-increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else begin
            unique case (dec.op)
                OP_FIRST:  addr <= {addr[ADDR_W-1:LO_W], dec.addr_lo};
                OP_SECOND: addr <= {dec.addr_hi, addr[LO_W-1:0]};
                OP_REG:    addr <= addr;
                OP_IDLE:   if (addr_inc) addr <= addr + step_ext;
            endcase
        end
    end

    // Access code: low bits come from the first word, high bits from the second.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= '0;
        else if (dec.op == OP_FIRST)
            code <= {code[CODE_W-1:CLO_W], dec.code_lo};
        else if (dec.op == OP_SECOND)
            code <= {dec.code_hi, code[CLO_W-1:0]};
    end
endmodule

// File: rtl/cmdp_regfile.sv
`timescale 1ns/1ps
// Module: cmdp_regfile
// Byte-wide configuration registers. Each one is loaded by an in-range
// register-write command. The auto-increment register is also brought out
// separately for the address stepper.
// Assumes: AUTOINC_IDX < NUM_REGS.
module cmdp_regfile
    import cmdp_pkg::*;
#(
    parameter int NUM_REGS    = 24,
    parameter int AUTOINC_IDX = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  cmd_dec_t                  dec,
    output logic [NUM_REGS*REG_W-1:0] regs,
    output logic [REG_W-1:0]          inc_step
);
    logic wr_en;

    // Write enable: a register-write command carrying an in-range index.
    always_comb wr_en = (dec.op == OP_REG) && dec.idx_ok;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        // Register k: reset to zero, load the command byte when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[k*REG_W +: REG_W] <= '0;
            else if (wr_en && (dec.idx == IDX_W'(k)))
                regs[k*REG_W +: REG_W] <= dec.val;
        end
    end

    // Tap the auto-increment register.
    assign inc_step = regs[AUTOINC_IDX*REG_W +: REG_W];
endmodule

// File: rtl/cmd_port_decoder.sv
`timescale 1ns/1ps
// Module: cmd_port_decoder (top)
// Command port decoder for a video controller. It classifies each command
// word, updates the register file or the address and code, and tracks
// whether the second word of a setup is still owed.
// Assumes: every strobe is a single-cycle pulse.
module cmd_port_decoder
    import cmdp_pkg::*;
#(
    parameter int NUM_REGS    = 24,
    parameter int AUTOINC_IDX = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_wr,
    input  logic [15:0]               cmd_data,
    input  logic                      data_wr,
    input  logic                      addr_inc,
    output logic [15:0]               addr_o,
    output logic [5:0]                code_o,
    output logic                      pending_o,
    output logic [NUM_REGS*8-1:0]     regs_o
);
    cmd_dec_t         dec;
    logic [REG_W-1:0] inc_step;

    cmdp_classify #(.NUM_REGS(NUM_REGS)) u_classify (
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .pending  (pending_o),
        .dec      (dec)
    );

    cmdp_access_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec      (dec),
        .data_wr  (data_wr),
        .addr_inc (addr_inc),
        .inc_step (inc_step),
        .addr     (addr_o),
        .code     (code_o),
        .pending  (pending_o)
    );

    cmdp_regfile #(.NUM_REGS(NUM_REGS), .AUTOINC_IDX(AUTOINC_IDX)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec      (dec),
        .regs     (regs_o),
        .inc_step (inc_step)
    );
endmodule

// File: rtl/cmd_port_decoder_chk.sv
`timescale 1ns/1ps
// Module: cmd_port_decoder_chk
// Port-level checker for cmd_port_decoder. It is attached to the top module
// by the bind statement at the end of this file.
module cmd_port_decoder_chk #(
    parameter int NUM_REGS    = 24,
    parameter int AUTOINC_IDX = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_wr,
    input logic [15:0]           cmd_data,
    input logic                  data_wr,
    input logic                  addr_inc,
    input logic [15:0]           addr_o,
    input logic [5:0]            code_o,
    input logic                  pending_o,
    input logic [NUM_REGS*8-1:0] regs_o
);
    // Select one register byte from the flat vector.
    function automatic logic [7:0] pick(input logic [NUM_REGS*8-1:0] v, input logic [4:0] i);
        pick = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (i == 5'(k)) pick = v[k*8 +: 8];
    endfunction

    logic reg_cmd, first_cmd, second_cmd;
    assign reg_cmd    = cmd_wr && !pending_o && (cmd_data[15:14] == 2'b10);
    assign first_cmd  = cmd_wr && !pending_o && (cmd_data[15:14] != 2'b10);
    assign second_cmd = cmd_wr && pending_o;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 && code_o == '0 && !pending_o && regs_o == '0));

    a_r2_reg_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        reg_cmd && (int'(cmd_data[12:8]) < NUM_REGS) |=>
            pick(regs_o, $past(cmd_data[12:8])) == $past(cmd_data[7:0]));

    a_r2_reg_write_keeps_access: assert property (@(posedge clk) disable iff (!rst_n)
        reg_cmd && !data_wr |=> $stable(addr_o) && $stable(code_o) && $stable(pending_o));

    a_r3_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        reg_cmd && (int'(cmd_data[12:8]) >= NUM_REGS) |=> $stable(regs_o));

    a_r4_first_word_merge: assert property (@(posedge clk) disable iff (!rst_n)
        first_cmd |=> addr_o[13:0] == $past(cmd_data[13:0])
                   && addr_o[15:14] == $past(addr_o[15:14])
                   && code_o[1:0] == $past(cmd_data[15:14])
                   && code_o[5:2] == $past(code_o[5:2]));

    a_r4_first_word_pends: assert property (@(posedge clk) disable iff (!rst_n)
        first_cmd && !data_wr |=> pending_o);

    a_r5_second_word_merge: assert property (@(posedge clk) disable iff (!rst_n)
        second_cmd |=> addr_o[15:14] == $past(cmd_data[1:0])
                    && addr_o[13:0] == $past(addr_o[13:0])
                    && code_o[5:2] == $past(cmd_data[7:4])
                    && code_o[1:0] == $past(code_o[1:0])
                    && !pending_o && $stable(regs_o));

    a_r6_data_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !pending_o);

    a_r7_increment_step: assert property (@(posedge clk) disable iff (!rst_n)
        addr_inc && !cmd_wr |=>
            addr_o == $past(addr_o) + {8'h00, $past(regs_o[AUTOINC_IDX*8 +: 8])});

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr && !addr_inc |=> $stable(addr_o) && $stable(code_o));
endmodule

bind cmd_port_decoder cmd_port_decoder_chk #(
    .NUM_REGS    (NUM_REGS),
    .AUTOINC_IDX (AUTOINC_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .data_wr   (data_wr),
    .addr_inc  (addr_inc),
    .addr_o    (addr_o),
    .code_o    (code_o),
    .pending_o (pending_o),
    .regs_o    (regs_o)
);

// File: tb/tb_cmd_port_decoder.sv
`timescale 1ns/1ps
// Directed bench for cmd_port_decoder. Each scenario task drives its own
// stimulus and checks its own results against expected values worked out
// from the requirements.
module tb_cmd_port_decoder;
    localparam int NR = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [15:0]   cmd_data = '0;
    logic          data_wr = 1'b0;
    logic          addr_inc = 1'b0;
    logic [15:0]   addr_o;
    logic [5:0]    code_o;
    logic          pending_o;
    logic [NR*8-1:0] regs_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_regs [NR];

    always #10 clk = ~clk;   // 50 MHz

    cmd_port_decoder dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .data_wr(data_wr), .addr_inc(addr_inc), .addr_o(addr_o),
        .code_o(code_o), .pending_o(pending_o), .regs_o(regs_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        logic [NR*8-1:0] e;
        for (int k = 0; k < NR; k++) e[k*8 +: 8] = exp_regs[k];
        checks++;
        if (regs_o !== e) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, regs_o, e);
        end
    endtask

    // One-cycle strobe of the chosen inputs, sampled at the following falling edge.
    task automatic pulse(input logic c, input logic [15:0] w, input logic d, input logic i);
        @(negedge clk);
        cmd_wr = c; cmd_data = w; data_wr = d; addr_inc = i;
        @(negedge clk);
        cmd_wr = 1'b0; data_wr = 1'b0; addr_inc = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NR; k++) exp_regs[k] = '0;
        chk("R1 addr", 32'(addr_o), 0);
        chk("R1 code", 32'(code_o), 0);
        chk("R1 pending", 32'(pending_o), 0);
        chk_regs("R1 regs");
    endtask

    task automatic t_reg_write();
        pulse(1, 16'h8F02, 0, 0); exp_regs[15] = 8'h02;
        pulse(1, 16'h8155, 0, 0); exp_regs[1]  = 8'h55;
        pulse(1, 16'h9733, 0, 0); exp_regs[23] = 8'h33;
        chk_regs("R2 regs");
        chk("R2 addr kept", 32'(addr_o), 0);
        chk("R2 code kept", 32'(code_o), 0);
        chk("R2 pending kept", 32'(pending_o), 0);
    endtask

    task automatic t_out_of_range();
        pulse(1, 16'h98AA, 0, 0);
        pulse(1, 16'h9FFF, 0, 0);
        chk_regs("R3 regs unchanged");
        chk("R3 pending", 32'(pending_o), 0);
    endtask

    task automatic t_setup();
        pulse(1, 16'h4123, 0, 0);
        chk("R4 pending set", 32'(pending_o), 1);
        chk("R4 addr", 32'(addr_o), 32'h0123);
        chk("R4 code", 32'(code_o), 32'h01);
        pulse(1, 16'h00F2, 0, 0);
        chk("R5 addr", 32'(addr_o), 32'h8123);
        chk("R5 code", 32'(code_o), 32'h3D);
        chk("R5 pending cleared", 32'(pending_o), 0);
        pulse(1, 16'hC000, 0, 0);
        chk("R4 addr keeps top", 32'(addr_o), 32'h8000);
        chk("R4 code keeps high", 32'(code_o), 32'h3F);
        pulse(1, 16'h8001, 0, 0);   // register pattern, but second word
        chk("R5 addr from tag word", 32'(addr_o), 32'h4000);
        chk("R5 code from tag word", 32'(code_o), 32'h03);
        chk_regs("R5 no register write");
    endtask

    task automatic t_data_clear();
        pulse(1, 16'h1234, 0, 0);
        chk("R4 addr", 32'(addr_o), 32'h5234);
        chk("R4 code", 32'(code_o), 32'h00);
        pulse(0, 16'h0000, 1, 0);
        chk("R6 pending cleared", 32'(pending_o), 0);
        pulse(1, 16'h8203, 0, 0); exp_regs[2] = 8'h03;
        chk_regs("R6 next word is register write");
        chk("R6 addr kept", 32'(addr_o), 32'h5234);
        pulse(1, 16'h0010, 1, 0);
        chk("R6 same-cycle addr", 32'(addr_o), 32'h4010);
        chk("R6 same-cycle pending", 32'(pending_o), 0);
    endtask

    task automatic t_increment();
        pulse(0, 16'h0000, 0, 1);
        chk("R7 step 2", 32'(addr_o), 32'h4012);
        pulse(0, 16'h0000, 0, 1);
        pulse(0, 16'h0000, 0, 1);
        chk("R7 step 2 x2", 32'(addr_o), 32'h4016);
        repeat (2) @(negedge clk);
        chk("R7 idle hold", 32'(addr_o), 32'h4016);
        pulse(1, 16'h8FFF, 0, 0); exp_regs[15] = 8'hFF;
        pulse(1, 16'h3FF0, 0, 0);
        pulse(1, 16'h0003, 0, 0);
        chk("R5 addr near max", 32'(addr_o), 32'hFFF0);
        pulse(0, 16'h0000, 0, 1);
        chk("R7 wrap", 32'(addr_o), 32'h00EF);
        chk("R7 code hold", 32'(code_o), 32'h00);
    endtask

    task automatic t_collide();
        pulse(1, 16'h0100, 0, 1);
        chk("R8 first word wins", 32'(addr_o), 32'h0100);
        pulse(1, 16'h0000, 0, 1);
        chk("R8 second word wins", 32'(addr_o), 32'h0100);
        pulse(1, 16'h8110, 0, 1); exp_regs[1] = 8'h10;
        chk("R8 register write drops step", 32'(addr_o), 32'h0100);
        chk_regs("R8 regs");
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_reg_write();
        t_out_of_range();
        t_setup();
        t_data_clear();
        t_increment();
        t_collide();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end
endmodule